// File: doc/BRIEF.md
# Parallel Port Floppy Pin Multiplexer

This block lets the drive interface of a floppy disk controller borrow the pins of a parallel port. A two-bit mode field picks one of three uses. In normal use the pins carry the parallel port. In one-drive sharing only drive 1 is reached through the port pins. In two-drive sharing both drive 0 and drive 1 are reached that way. The block sits between the floppy controller, the parallel port engine and the pads. It steers each outgoing signal to the correct pins and sets the output enables. It steers the returning floppy inputs back to the controller. It also forms the values that software reads from the parallel data, control and status registers.

While either sharing mode is set, the parallel port function is off. Its register reads return fixed values that look like an unplugged cable. The port DMA request follows a fixed safe rule. The native floppy pins are released to high impedance only while the drive select picks a drive that is routed to the port. Floppy routing does not depend on the parallel port power bit.

Top module: `ppfd_mux`

## Requirements
- R1: The mode field resets to 00 and takes a value written with `cfg_we` from the next cycle on. Value 01 is one-drive sharing. Value 10 is two-drive sharing. Value 11 behaves as two-drive sharing.
- R2: In normal mode (00) with `pwr_on`=1, the port pins carry the engine outputs. `pin_d_o`=`par_dout` with `pin_d_oe`=`par_oe`, and `pin_c_o`=`par_ctl` with `pin_c_oe`=1. `nat_out` always equals `fd_out`.
- R3: In one-drive mode only `drv_sel`=1 routes the drive to the port. In that case `pin_d_o[6]` (drive 0 select) and `pin_c_o[0]` (motor 0) are forced to 1.
- R4: In two-drive mode, `drv_sel`=0 or 1 routes the drive to the port. `pin_d_o`=`fd_out[7:0]` and `pin_c_o`=`{2'b11, fd_out[9:8]}`.
- R5: While a routed drive is selected, `nat_oe`=0 and `fd_in`=`pin_s_i`. Otherwise `nat_oe`=1 and `fd_in`=`nat_in`.
- R6: In a sharing mode, both pin groups are enabled. When no routed drive is selected, they drive all ones.
- R7: In a sharing mode, `rd_ctl`=4'b1000 and `rd_stat`=5'b01001. `rd_ctl` bits [3:0] are nINIT, SLC, AUTOFD, STROBE. `rd_stat` bits [4:0] are nBUSY, nACK, PE, SLCT, nERR. In normal mode, `rd_ctl`=`par_ctl` and `rd_stat`=`pin_s_i`.
- R8: In a sharing mode, `rd_data` is the byte most recently written with `par_data_we` (reset value 0). In normal mode, `rd_data`=`pin_d_i`.
- R9: The parallel function is on only in mode 00 with `pwr_on`=1. While it is off, `pin_d_oe`=0 in normal mode, `pin_c_oe`=0 in normal mode, `pin_irq_oe`=0 and `par_dack_n`=1. While it is on, `pin_irq_o`=`par_irq` with `pin_irq_oe`=1, and `par_dack_n`=`pin_dack_n_i`.
- R10: While the parallel function is off, `pin_drq_o`=0 and `pin_drq_oe`=`ecp_mode & dma_en`. While it is on, `pin_drq_o`=`par_dma_req` with `pin_drq_oe`=1.
- R11: Floppy routing, `nat_oe`, `fd_in` and the sharing pin values do not depend on `pwr_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Mode field write strobe |
| cfg_mode | input | 2 | Mode field write value |
| pwr_on | input | 1 | Parallel port power control |
| ecp_mode | input | 1 | Port engine in ECP mode |
| dma_en | input | 1 | Port DMA enabled |
| drv_sel | input | 2 | Floppy drive select value |
| fd_out | input | 10 | Floppy outputs: wdata_n, densel, hdsel_n, wgate_n, dir_n, step_n, ds0_n, ds1_n, mtr0_n, mtr1_n (bit 0 up) |
| fd_in | output | 5 | Floppy inputs to controller (index, trk0, wprot, rdata, dskchg) |
| nat_out | output | 10 | Native floppy output pins |
| nat_oe | output | 1 | Native floppy output enable |
| nat_in | input | 5 | Native floppy input pins |
| par_data_we | input | 1 | Data register write strobe |
| par_data_wr | input | 8 | Data register write value |
| par_dout | input | 8 | Engine data pin value |
| par_oe | input | 1 | Engine data pin enable |
| par_ctl | input | 4 | Engine control pin values |
| par_dma_req | input | 1 | Engine DMA request |
| par_irq | input | 1 | Engine interrupt |
| par_dack_n | output | 1 | DMA acknowledge to engine |
| pin_d_o | output | 8 | Data pins out |
| pin_d_oe | output | 1 | Data pins enable |
| pin_d_i | input | 8 | Data pins in |
| pin_c_o | output | 4 | Control pins out |
| pin_c_oe | output | 1 | Control pins enable |
| pin_s_i | input | 5 | Status pins in |
| pin_dack_n_i | input | 1 | DMA acknowledge pin |
| pin_drq_o | output | 1 | DMA request pin |
| pin_drq_oe | output | 1 | DMA request enable |
| pin_irq_o | output | 1 | Interrupt pin |
| pin_irq_oe | output | 1 | Interrupt enable |
| rd_data | output | 8 | Data register read-back |
| rd_ctl | output | 4 | Control register read-back |
| rd_stat | output | 5 | Status register read-back |

## Verification
The block has no width parameters, so the bench builds it with its fixed widths. It visits all four mode values, including 11, which must behave like two-drive sharing. For each mode it covers all four drive selects and every mix of power, ECP and DMA enable, with fresh random pin and engine values each cycle. This reaches the cases where routing and the power bit disagree, the drive-0 masking in one-drive mode, and the DMA request rule in every off state. Data writes made during sharing test that the held byte tracks the last write.

// File: rtl/ppfd_mux.sv
module ppfd_mux (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_mode,
  input  logic       pwr_on,
  input  logic       ecp_mode,
  input  logic       dma_en,
  input  logic [1:0] drv_sel,
  input  logic [9:0] fd_out,
  output logic [4:0] fd_in,
  output logic [9:0] nat_out,
  output logic       nat_oe,
  input  logic [4:0] nat_in,
  input  logic       par_data_we,
  input  logic [7:0] par_data_wr,
  input  logic [7:0] par_dout,
  input  logic       par_oe,
  input  logic [3:0] par_ctl,
  input  logic       par_dma_req,
  input  logic       par_irq,
  output logic       par_dack_n,
  output logic [7:0] pin_d_o,
  output logic       pin_d_oe,
  input  logic [7:0] pin_d_i,
  output logic [3:0] pin_c_o,
  output logic       pin_c_oe,
  input  logic [4:0] pin_s_i,
  input  logic       pin_dack_n_i,
  output logic       pin_drq_o,
  output logic       pin_drq_oe,
  output logic       pin_irq_o,
  output logic       pin_irq_oe,
  output logic [7:0] rd_data,
  output logic [3:0] rd_ctl,
  output logic [4:0] rd_stat
);
  localparam logic [3:0] CTL_UNPLUGGED  = 4'b1000;
  localparam logic [4:0] STAT_UNPLUGGED = 5'b01001;

  logic [1:0] mode_q;
  logic [7:0] data_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= 2'b00;
      data_q <= 8'h00;
    end else begin
      if (cfg_we)      mode_q <= cfg_mode;
      if (par_data_we) data_q <= par_data_wr;
    end

  logic sharing, two_drv, routed, pp_on;
  assign sharing = |mode_q;
  assign two_drv = mode_q[1];
  assign routed  = two_drv ? !drv_sel[1] : (mode_q[0] && drv_sel == 2'd1);
  assign pp_on   = !sharing && pwr_on;

  logic [9:0] fd_port;
  always_comb begin
    fd_port = fd_out;
    if (!two_drv) begin
      fd_port[6] = 1'b1;
      fd_port[8] = 1'b1;
    end
    if (!routed) fd_port = '1;
  end

  assign nat_out = fd_out;
  assign nat_oe  = !routed;
  assign fd_in   = routed ? pin_s_i : nat_in;

  assign pin_d_o  = sharing ? fd_port[7:0] : par_dout;
  assign pin_d_oe = sharing ? 1'b1 : (pp_on && par_oe);
  assign pin_c_o  = sharing ? {2'b11, fd_port[9:8]} : par_ctl;
  assign pin_c_oe = sharing || pp_on;

  assign par_dack_n = pp_on ? pin_dack_n_i : 1'b1;
  assign pin_drq_o  = pp_on && par_dma_req;
  assign pin_drq_oe = pp_on || (ecp_mode && dma_en);
  assign pin_irq_o  = pp_on && par_irq;
  assign pin_irq_oe = pp_on;

  assign rd_data = sharing ? data_q : pin_d_i;
  assign rd_ctl  = sharing ? CTL_UNPLUGGED : par_ctl;
  assign rd_stat = sharing ? STAT_UNPLUGGED : pin_s_i;

  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(mode_q));
  p_native_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nat_oe |-> fd_in == nat_in);
  p_cable_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'b00) |-> (rd_ctl == 4'b1000 && rd_stat == 5'b01001));
  p_data_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sharing && !cfg_we && !par_data_we) |=> $stable(rd_data));
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> !pin_irq_oe);
  p_drq_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sharing && pin_drq_oe) |-> !pin_drq_o);
  p_one_drive_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01) |-> (pin_d_o[6] && pin_c_o[0]));
endmodule

// File: tb/ppfd_mux_tb.sv
module ppfd_mux_tb;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic cfg_we = 0, pwr_on = 1, ecp_mode = 0, dma_en = 0;
  logic [1:0] cfg_mode = 0, drv_sel = 0;
  logic [9:0] fd_out = 0, nat_out;
  logic [4:0] fd_in, nat_in = 0, pin_s_i = 0, rd_stat;
  logic nat_oe, par_data_we = 0, par_oe = 0, par_dma_req = 0, par_irq = 0;
  logic par_dack_n, pin_d_oe, pin_c_oe, pin_dack_n_i = 0;
  logic pin_drq_o, pin_drq_oe, pin_irq_o, pin_irq_oe;
  logic [7:0] par_data_wr = 0, par_dout = 0, pin_d_o, pin_d_i = 0, rd_data;
  logic [3:0] par_ctl = 0, pin_c_o, rd_ctl;

  ppfd_mux u_dut (.*);

  int total = 0, bad = 0;
  int m_mode = 0;
  logic [7:0] m_data = 0;
  bit live = 0, done = 0;

  always @(posedge clk)
    if (!rst_n) begin m_mode <= 0; m_data <= 0; end
    else begin
      if (cfg_we) m_mode <= int'(cfg_mode);
      if (par_data_we) m_data <= par_data_wr;
    end

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (live) begin
    bit sh, two, rt, on;
    logic [7:0] ed; logic [3:0] ec;
    string rtag;
    sh = m_mode != 0; two = m_mode >= 2; on = !sh && pwr_on;
    rt = (two && drv_sel <= 1) || (m_mode == 1 && drv_sel == 1);
    rtag = two ? "R4" : (m_mode == 1 ? "R3" : "R2");
    chk("R2", "nat_out", {6'd0, nat_out}, {6'd0, fd_out});
    chk(pwr_on ? "R5" : "R11", "nat_oe", {15'd0, nat_oe}, {15'd0, !rt});
    chk(pwr_on ? "R5" : "R11", "fd_in", {11'd0, fd_in}, {11'd0, rt ? pin_s_i : nat_in});
    if (sh) begin
      ed = 8'hFF; ec = 4'hF;
      if (rt) begin
        ed = fd_out[7:0]; ec = {2'b11, fd_out[9:8]};
        if (!two) begin ed[6] = 1; ec[0] = 1; end
      end
      chk(rt ? rtag : "R6", "pin_d_o", {8'd0, pin_d_o}, {8'd0, ed});
      chk(rt ? rtag : "R6", "pin_c_o", {12'd0, pin_c_o}, {12'd0, ec});
      chk("R6", "pin_oe", {14'd0, pin_d_oe, pin_c_oe}, 16'd3);
      chk("R7", "rd_ctl", {12'd0, rd_ctl}, 16'h0008);
      chk("R7", "rd_stat", {11'd0, rd_stat}, 16'h0009);
      chk("R8", "rd_data", {8'd0, rd_data}, {8'd0, m_data});
    end else begin
      chk(on ? "R2" : "R9", "pin_d_oe", {15'd0, pin_d_oe}, {15'd0, on && par_oe});
      chk(on ? "R2" : "R9", "pin_c_oe", {15'd0, pin_c_oe}, {15'd0, on});
      if (on) begin
        chk("R2", "pin_d_o", {8'd0, pin_d_o}, {8'd0, par_dout});
        chk("R2", "pin_c_o", {12'd0, pin_c_o}, {12'd0, par_ctl});
      end
      chk("R7", "rd_ctl", {12'd0, rd_ctl}, {12'd0, par_ctl});
      chk("R7", "rd_stat", {11'd0, rd_stat}, {11'd0, pin_s_i});
      chk("R8", "rd_data", {8'd0, rd_data}, {8'd0, pin_d_i});
    end
    chk("R9", "irq", {14'd0, pin_irq_oe, pin_irq_o}, {14'd0, on, on && par_irq});
    chk("R9", "dack", {15'd0, par_dack_n}, {15'd0, on ? pin_dack_n_i : 1'b1});
    chk("R10", "drq", {14'd0, pin_drq_oe, pin_drq_o},
        {14'd0, on || (ecp_mode && dma_en), on && par_dma_req});
  end

  task automatic scramble();
    fd_out = 10'($urandom); nat_in = 5'($urandom); pin_s_i = 5'($urandom);
    par_dout = 8'($urandom); par_oe = 1'($urandom); par_ctl = 4'($urandom);
    par_dma_req = 1'($urandom); par_irq = 1'($urandom);
    pin_d_i = 8'($urandom); pin_dack_n_i = 1'($urandom);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1; live = 1;
    @(negedge clk);
    chk("R1", "reset mode: rd_ctl follows engine", {12'd0, rd_ctl}, {12'd0, par_ctl});
    chk("R1", "reset nat_oe", {15'd0, nat_oe}, 16'd1);
    for (int m = 0; m < 4; m++) begin
      @(posedge clk); #2 cfg_we = 1; cfg_mode = 2'(m);
      par_data_we = 1; par_data_wr = 8'($urandom);
      @(posedge clk); #2 cfg_we = 0; par_data_we = 0;
      for (int c = 0; c < 32; c++) begin
        drv_sel = 2'(c >> 3); pwr_on = c[2]; ecp_mode = c[1]; dma_en = c[0];
        scramble();
        par_data_we = (c % 5 == 0); par_data_wr = 8'($urandom);
        @(posedge clk); #2 par_data_we = 0;
      end
    end
    @(posedge clk); #2 cfg_we = 1; cfg_mode = 0;
    @(posedge clk); #2 cfg_we = 0; pwr_on = 1; scramble();
    @(posedge clk); #2;
    live = 0; done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule